// File: doc/BRIEF.md
# Eligible-Time Gated Egress Queue

This block is a single first-in first-out queue of packet descriptors with time-triggered release. An upstream admission stage writes each accepted descriptor together with a 64-bit eligible timestamp. The queue never reorders entries, so arranging them in a useful order is the admission stage's job. The entry at the head is offered to the transmit port only once the synchronized network time, the same time base the admission stage uses, has reached that entry's stamp. The link may therefore sit idle while entries wait. A stamp of zero releases the entry as soon as it reaches the head, which gives work-conserving behaviour.

Internally, a ring store holds the waiting entries and a registered head stage holds the entry being offered. The head stage is a three-state machine:
- `HD_EMPTY`: no entry is held.
- `HD_WAIT`: an entry is held but its stamp lies in the future.
- `HD_SEND`: the entry is offered on the read side.

Its transitions are:
- load-eligible (`HD_EMPTY`→`HD_SEND`)
- load-early (`HD_EMPTY`→`HD_WAIT`)
- time-reached (`HD_WAIT`→`HD_SEND`)
- handshake-refill eligible (`HD_SEND`→`HD_SEND`)
- handshake-refill early (`HD_SEND`→`HD_WAIT`)
- handshake-drain (`HD_SEND`→`HD_EMPTY`)

Each stamp is compared once, when its entry moves into the head stage, and the held entry's stamp is compared on every cycle after that. Network time is assumed never to decrease.

Top module: `timed_egress_queue`

## Requirements
- R1: After reset, rd_valid, wr_full and wr_reject are all low.
- R2: Descriptors leave in exactly the order their writes were accepted.
- R3: A held entry is offered only once now_time >= its stamp, compared unsigned over 64 bits. rd_valid rises right after the first clock edge at which that condition is sampled.
- R4: A stamp of 0 is work-conserving. A write accepted at edge N into an empty queue gives rd_valid high right after edge N+1.
- R5: Entries with equal stamps leave on consecutive cycles when rd_ready is held high.
- R6: While rd_valid is high and rd_ready is low, rd_valid stays high and rd_desc stays unchanged.
- R7: wr_full is high when the queue holds 2**DEPTH_LOG2 entries, counting the head. A write while full is dropped and not stored. wr_reject is then high for exactly the one cycle after that edge.
- R8: When the queue is not full, a read and a write in the same cycle are both accepted and the occupancy stays the same. While full, a write is refused even if a read happens in the same cycle.
- R9: An entry with an earlier stamp never overtakes the head. It waits behind the head even if its own time has come.
- R10: A stamp with bit 63 set is not eligible for any now_time below it, because the comparison is unsigned rather than signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_desc | input | DESC_W | Descriptor to enqueue |
| wr_time | input | TIME_W | Eligible timestamp of the descriptor |
| wr_full | output | 1 | Queue holds its full capacity |
| wr_reject | output | 1 | A write was refused at the previous edge |
| now_time | input | TIME_W | Synchronized network time |
| rd_valid | output | 1 | Head descriptor offered |
| rd_desc | output | DESC_W | Head descriptor |
| rd_ready | input | 1 | Transmit port takes the head |

## Verification
The hardest situation to reach from the ports is a queue sitting exactly one entry below capacity while a read and a write land on the same edge. The bench fills the queue with zero-stamp entries while rd_ready is held low, so the head stays parked in `HD_SEND`. It then raises write and ready together for a single cycle, checks that wr_full stays low, and fills the last slot. Head-of-line blocking is reached by holding network time between two stamps. This leaves an early-stamped entry stuck behind a late one, and the bench then releases both by moving time forward.

// File: rtl/teq_pkg.sv
package teq_pkg;
    typedef enum logic [1:0] {
        HD_EMPTY = 2'd0,
        HD_WAIT  = 2'd1,
        HD_SEND  = 2'd2
    } head_st_e;
endpackage

// File: rtl/teq_gate.sv
module teq_gate #(
    parameter int TIME_W = 64
) (
    input  logic [TIME_W-1:0] now_time,
    input  logic [TIME_W-1:0] stamp,
    output logic              reached
);
    // unsigned magnitude compare: the stamp has been reached once time is at or past it
    always_comb reached = (now_time >= stamp);
endmodule

// File: rtl/teq_ring.sv
module teq_ring #(
    parameter int W  = 96,
    parameter int AW = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         nonempty
);
    localparam int SLOTS = 1 << AW;

    logic [W-1:0]  mem [SLOTS];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   fill;

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_comb begin
        rdata    = mem[rptr];
        nonempty = (fill != '0);
    end

    // R2
    ring_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (fill != '0));
    // R7
    ring_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (fill < (AW+1)'(SLOTS)));
endmodule

// File: rtl/teq_head.sv
module teq_head
    import teq_pkg::*;
#(
    parameter int DESC_W = 32,
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now_time,
    input  logic              src_valid,
    input  logic [DESC_W-1:0] src_desc,
    input  logic [TIME_W-1:0] src_time,
    output logic              src_pop,
    output logic              rd_valid,
    output logic [DESC_W-1:0] rd_desc,
    input  logic              rd_ready
);
    head_st_e          st_q, st_d;
    logic [DESC_W-1:0] desc_q;
    logic [TIME_W-1:0] time_q;
    logic              src_reached, held_reached;

    teq_gate #(.TIME_W(TIME_W)) u_src_gate (
        .now_time(now_time), .stamp(src_time), .reached(src_reached));
    teq_gate #(.TIME_W(TIME_W)) u_held_gate (
        .now_time(now_time), .stamp(time_q), .reached(held_reached));

    // next state and refill decision
    always_comb begin
        st_d    = st_q;
        src_pop = 1'b0;
        unique case (st_q)
            HD_EMPTY: begin
                if (src_valid) begin
                    src_pop = 1'b1;
                    st_d    = src_reached ? HD_SEND : HD_WAIT;
                end
            end
            HD_WAIT: begin
                if (held_reached) st_d = HD_SEND;
            end
            HD_SEND: begin
                if (rd_ready) begin
                    if (src_valid) begin
                        src_pop = 1'b1;
                        st_d    = src_reached ? HD_SEND : HD_WAIT;
                    end else begin
                        st_d = HD_EMPTY;
                    end
                end
            end
            default: st_d = HD_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= HD_EMPTY;
        else        st_q <= st_d;
    end

    // held entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q <= '0;
            time_q <= '0;
        end else if (src_pop) begin
            desc_q <= src_desc;
            time_q <= src_time;
        end
    end

    // outputs
    always_comb begin
        rd_valid = (st_q == HD_SEND);
        rd_desc  = desc_q;
    end

    // R3
    release_after_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (now_time >= time_q));
    // R6
    hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_desc)));
    // R3
    wait_not_offered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HD_WAIT && !held_reached) |=> !rd_valid);
endmodule

// File: rtl/timed_egress_queue.sv
module timed_egress_queue #(
    parameter int DESC_W     = 32,
    parameter int TIME_W     = 64,
    parameter int DEPTH_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DESC_W-1:0] wr_desc,
    input  logic [TIME_W-1:0] wr_time,
    output logic              wr_full,
    output logic              wr_reject,
    input  logic [TIME_W-1:0] now_time,
    output logic              rd_valid,
    output logic [DESC_W-1:0] rd_desc,
    input  logic              rd_ready
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam int ENT_W = DESC_W + TIME_W;
    localparam int CNT_W = DEPTH_LOG2 + 1;

    logic [CNT_W-1:0]  occ;
    logic              push, take;
    logic              ring_pop, ring_nonempty;
    logic [ENT_W-1:0]  ring_rdata;
    logic              reject_q;

    always_comb begin
        wr_full   = (occ == CNT_W'(DEPTH));
        push      = wr_valid && !wr_full;
        take      = rd_valid && rd_ready;
        wr_reject = reject_q;
    end

    teq_ring #(.W(ENT_W), .AW(DEPTH_LOG2)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .wdata    ({wr_desc, wr_time}),
        .pop      (ring_pop),
        .rdata    (ring_rdata),
        .nonempty (ring_nonempty)
    );

    teq_head #(.DESC_W(DESC_W), .TIME_W(TIME_W)) u_head (
        .clk       (clk),
        .rst_n     (rst_n),
        .now_time  (now_time),
        .src_valid (ring_nonempty),
        .src_desc  (ring_rdata[ENT_W-1:TIME_W]),
        .src_time  (ring_rdata[TIME_W-1:0]),
        .src_pop   (ring_pop),
        .rd_valid  (rd_valid),
        .rd_desc   (rd_desc),
        .rd_ready  (rd_ready)
    );

    // occupancy across ring and head
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ      <= '0;
            reject_q <= 1'b0;
        end else begin
            case ({push, take})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
            reject_q <= wr_valid && wr_full;
        end
    end

    // R7
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));
    // R7
    reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_full) |=> wr_reject);
    // R8
    full_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_full && wr_valid && !take) |=> wr_full);
    // R2
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !rd_valid);
endmodule

// File: tb/timed_egress_queue_test.sv
module timed_egress_queue_test;
    localparam int DW = 32;
    localparam int TW = 64;
    localparam int DL = 3;
    localparam int DEPTH = 1 << DL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_desc = '0;
    logic [TW-1:0] wr_time = '0;
    logic          wr_full, wr_reject;
    logic [TW-1:0] now_time = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_desc;
    logic          rd_ready = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [DW-1:0] model[$];

    timed_egress_queue #(.DESC_W(DW), .TIME_W(TW), .DEPTH_LOG2(DL)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_desc(wr_desc),
        .wr_time(wr_time), .wr_full(wr_full), .wr_reject(wr_reject),
        .now_time(now_time), .rd_valid(rd_valid), .rd_desc(rd_desc),
        .rd_ready(rd_ready));

    always #4 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                total++; bad++;
                $display("FAIL watchdog act=%0d exp<=100000", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic chk(string req, logic [TW-1:0] act, logic [TW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // one-cycle write; returns at the negedge after the capturing edge
    task automatic push(logic [DW-1:0] d, logic [TW-1:0] t);
        @(negedge clk);
        wr_valid = 1'b1; wr_desc = d; wr_time = t;
        @(negedge clk);
        wr_valid = 1'b0;
        model.push_back(d);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drain with ready high; check order and back-to-back spacing when asked
    task automatic drain(string req, bit b2b);
        int gap = 0;
        bit started = 0;
        @(negedge clk);
        rd_ready = 1'b1;
        for (int i = 0; i < 200 && model.size() > 0; i++) begin
            if (rd_valid) begin
                chk(req, rd_desc, model.pop_front());
                if (b2b && started) chk("R5 back-to-back gap", gap, 0);
                started = 1; gap = 0;
            end else if (started) begin
                gap++;
            end
            @(negedge clk);
        end
        chk({req, " drained"}, model.size(), 0);
        rd_ready = 1'b0;
        idle(1);
        chk({req, " empty after drain"}, rd_valid, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 wr_full", wr_full, 0);
        chk("R1 wr_reject", wr_reject, 0);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic t_work_conserving();
        now_time = 64'd10;
        @(negedge clk);
        wr_valid = 1'b1; wr_desc = 32'hA1; wr_time = 64'd0;
        @(negedge clk);               // after edge N
        wr_valid = 1'b0;
        model.push_back(32'hA1);
        chk("R4 not yet after edge N", rd_valid, 0);
        @(negedge clk);               // after edge N+1
        chk("R4 valid after edge N+1", rd_valid, 1);
        push(32'hA2, 64'd0);
        push(32'hA3, 64'd5);
        drain("R2 order", 0);
    endtask

    task automatic t_gate_hold();
        now_time = 64'd100;
        push(32'hB1, 64'd150);
        idle(3);
        chk("R3 early stamp held", rd_valid, 0);
        now_time = 64'd149;
        idle(2);
        chk("R3 one short", rd_valid, 0);
        now_time = 64'd150;           // sampled at the next edge
        chk("R3 before edge", rd_valid, 0);
        @(negedge clk);
        chk("R3 released", rd_valid, 1);
        chk("R3 desc", rd_desc, 32'hB1);
        idle(3);
        chk("R6 still valid", rd_valid, 1);
        chk("R6 desc stable", rd_desc, 32'hB1);
        drain("R6 taken", 0);
    endtask

    task automatic t_hol();
        now_time = 64'd200;
        push(32'hC1, 64'd500);
        push(32'hC2, 64'd0);
        rd_ready = 1'b1;
        idle(4);
        chk("R9 early entry blocked", rd_valid, 0);
        rd_ready = 1'b0;
        now_time = 64'd500;
        drain("R9 order", 1);
    endtask

    task automatic t_same_stamp();
        now_time = 64'd1000;
        for (int i = 0; i < 4; i++) push(32'hD0 + DW'(i), 64'd2000);
        idle(2);
        chk("R5 waiting", rd_valid, 0);
        now_time = 64'd2000;
        drain("R5 order", 1);
    endtask

    task automatic t_full();
        now_time = 64'd5000;
        for (int i = 0; i < DEPTH - 1; i++) push(32'hE0 + DW'(i), 64'd0);
        idle(2);
        chk("R8 not full at depth-1", wr_full, 0);
        chk("R8 head offered", rd_valid, 1);
        // simultaneous read and write
        @(negedge clk);
        wr_valid = 1'b1; wr_desc = 32'hEE; wr_time = 64'd0; rd_ready = 1'b1;
        void'(model.pop_front());
        model.push_back(32'hEE);
        @(negedge clk);
        wr_valid = 1'b0; rd_ready = 1'b0;
        chk("R8 occupancy kept", wr_full, 0);
        push(32'hEF, 64'd0);
        chk("R7 full", wr_full, 1);
        @(negedge clk);
        wr_valid = 1'b1; wr_desc = 32'hBAD; wr_time = 64'd0;
        @(negedge clk);
        wr_valid = 1'b0;
        chk("R7 reject flag", wr_reject, 1);
        @(negedge clk);
        chk("R7 reject one cycle", wr_reject, 0);
        // write while full with read in the same cycle: still refused
        @(negedge clk);
        wr_valid = 1'b1; wr_desc = 32'hBAE; rd_ready = 1'b1;
        void'(model.pop_front());
        @(negedge clk);
        wr_valid = 1'b0; rd_ready = 1'b0;
        chk("R8 refused with read", wr_reject, 1);
        chk("R8 one slot freed", wr_full, 0);
        drain("R7 dropped writes absent", 0);
        chk("R7 not full after drain", wr_full, 0);
    endtask

    task automatic t_unsigned();
        now_time = 64'd6000;
        push(32'hF1, 64'h8000_0000_0000_0010);
        rd_ready = 1'b1;
        idle(4);
        chk("R10 large stamp held", rd_valid, 0);
        rd_ready = 1'b0;
        now_time = 64'h8000_0000_0000_000F;
        idle(2);
        chk("R10 one below", rd_valid, 0);
        now_time = 64'h8000_0000_0000_0010;
        drain("R10 released", 0);
    endtask

    initial begin
        t_reset();
        t_work_conserving();
        t_gate_hold();
        t_hol();
        t_same_stamp();
        t_full();
        t_unsigned();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule